// File: doc/BRIEF.md
# Double-Buffered Addressed DAC Input Register

This block is the register file that sits between a processor bus and a 12-bit digital-to-analog converter. It has a 12-bit data port, an active-low chip select and four active-low address enables. Data reaches the converter through two ranks. The first rank is made of three 4-bit staging registers, one for each nibble of the code. The second rank is a single 12-bit code register that drives the converter. Narrow buses can build up a complete code one nibble or one byte at a time. The finished code then moves to the converter in a single step, so the converter never sees a half-written value.

The enables are decoded by one combinational decode stage. Its operation classes are named IDLE, STAGE, COMMIT, STAGE_COMMIT and FLOW. IDLE covers chip select high, or every address line high. STAGE means only nibble enables are active. COMMIT means only the transfer enable is active. STAGE_COMMIT means nibble enables and the transfer enable are active together. FLOW means every address line is low. Each class maps to a set of register enables through a unique case. There is no sequential controller: each register follows its input on every clock edge where its enable is active and holds its value on every other edge. In this way the level-sensitive latches are modelled synchronously.

Top module: `dbuf_dac_latch`

## Requirements
- R1: An active-high reset `rst` clears the three staging nibbles and the code register to zero. After reset, `code_o` reads 0x000, and a transfer with no nibble write also yields 0x000.
- R2: While `sel_n` is high, no register changes, whatever the value of `addr_n`.
- R3: While `sel_n` is low and `addr_n` is 4'b1111, no register changes.
- R4: With `sel_n` low, `addr_n[0]` low loads `data_i[3:0]` into the low staging nibble. `addr_n[1]` low loads `data_i[7:4]` into the middle nibble. `addr_n[2]` low loads `data_i[11:8]` into the high nibble.
- R5: Nibble writes made while `addr_n[3]` is high leave `code_o` unchanged.
- R6: With `sel_n` low, `addr_n[3]` low and `addr_n[2:0]` = 3'b111, the code register takes the staged value {high, middle, low}. `code_o` shows it after that same clock edge.
- R7: When one or more nibble enables are active on the same edge as `addr_n[3]`, the code register takes the newly written nibbles together with the held ones.
- R8: With `sel_n` low and `addr_n` = 4'b0000, the whole path is transparent: `code_o` equals the `data_i` sampled at each edge.
- R9: Once an enable returns high, the register keeps the value it captured, even if `data_i` changes afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | 12 | Bus data; bits 3:0, 7:4 and 11:8 feed the low, middle and high nibbles |
| sel_n | input | 1 | Chip select, active low |
| addr_n | input | 4 | Register enables, active low: bits 0-2 select a nibble, bit 3 selects the transfer |
| code_o | output | 12 | Converter code held in the second rank |

## Verification
Every result is due exactly one rising edge after the enable and data that cause it are sampled. A staging nibble and the code register both update on that edge, including a combined stage-and-commit. The bench drives inputs on the falling edge and compares `code_o` one nanosecond after the next rising edge, so each comparison sees exactly one edge's effect. A bench-side model is updated from the requirement rules at the same point. Staged content cannot be seen directly, so it is checked through a later commit, and that commit is due on its own single edge.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    parameter int DBUF_NIB_W   = 4;
    parameter int DBUF_NIB_CNT = 3;

    typedef enum logic [2:0] {
        OP_IDLE         = 3'd0,
        OP_STAGE        = 3'd1,
        OP_COMMIT       = 3'd2,
        OP_STAGE_COMMIT = 3'd3,
        OP_FLOW         = 3'd4
    } dbuf_op_e;

endpackage

// File: rtl/dbuf_decode.sv
module dbuf_decode
    import dbuf_pkg::*;
#(
    parameter int NIB_CNT = DBUF_NIB_CNT,
    localparam int ADDR_W = NIB_CNT + 1
) (
    input  logic               sel_n,
    input  logic [ADDR_W-1:0]  addr_n,
    output logic [NIB_CNT-1:0] stage_en,
    output logic               commit_en
);

    dbuf_op_e op;
    logic     any_stage;
    logic     commit_req;

    assign any_stage  = ~&addr_n[NIB_CNT-1:0];
    assign commit_req = ~addr_n[NIB_CNT];

    // classify the select/address combination
    always_comb begin
        if (sel_n || (&addr_n)) begin
            op = OP_IDLE;
        end else if (addr_n == '0) begin
            op = OP_FLOW;
        end else if (commit_req && any_stage) begin
            op = OP_STAGE_COMMIT;
        end else if (commit_req) begin
            op = OP_COMMIT;
        end else begin
            op = OP_STAGE;
        end
    end

    // map each class to register enables
    always_comb begin
        unique case (op)
            OP_IDLE: begin
                stage_en  = '0;
                commit_en = 1'b0;
            end
            OP_STAGE: begin
                stage_en  = ~addr_n[NIB_CNT-1:0];
                commit_en = 1'b0;
            end
            OP_COMMIT: begin
                stage_en  = '0;
                commit_en = 1'b1;
            end
            OP_STAGE_COMMIT: begin
                stage_en  = ~addr_n[NIB_CNT-1:0];
                commit_en = 1'b1;
            end
            OP_FLOW: begin
                stage_en  = '1;
                commit_en = 1'b1;
            end
            default: begin
                stage_en  = '0;
                commit_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dbuf_nibble_reg.sv
module dbuf_nibble_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);

    // value presented after the coming edge
    assign nxt = en ? d : q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/dbuf_code_reg.sv
module dbuf_code_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/dbuf_dac_latch.sv
module dbuf_dac_latch
    import dbuf_pkg::*;
#(
    parameter int NIB_W   = DBUF_NIB_W,
    parameter int NIB_CNT = DBUF_NIB_CNT,
    localparam int CODE_W = NIB_W * NIB_CNT,
    localparam int ADDR_W = NIB_CNT + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] data_i,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr_n,
    output logic [CODE_W-1:0] code_o
);

    logic [NIB_CNT-1:0] stage_en;
    logic               commit_en;
    logic [CODE_W-1:0]  stage_q;
    logic [CODE_W-1:0]  stage_nxt;

    dbuf_decode #(
        .NIB_CNT (NIB_CNT)
    ) u_decode (
        .sel_n     (sel_n),
        .addr_n    (addr_n),
        .stage_en  (stage_en),
        .commit_en (commit_en)
    );

    for (genvar k = 0; k < NIB_CNT; k++) begin : g_stage
        dbuf_nibble_reg #(
            .W (NIB_W)
        ) u_nib (
            .clk (clk),
            .rst (rst),
            .en  (stage_en[k]),
            .d   (data_i[k*NIB_W +: NIB_W]),
            .q   (stage_q[k*NIB_W +: NIB_W]),
            .nxt (stage_nxt[k*NIB_W +: NIB_W])
        );
    end

    // the second rank samples what the first rank will hold after this edge
    dbuf_code_reg #(
        .W (CODE_W)
    ) u_code (
        .clk (clk),
        .rst (rst),
        .en  (commit_en),
        .d   (stage_nxt),
        .q   (code_o)
    );

endmodule

// File: rtl/dbuf_dac_latch_chk.sv
module dbuf_dac_latch_chk #(
    parameter int NIB_W   = 4,
    parameter int NIB_CNT = 3,
    localparam int CODE_W = NIB_W * NIB_CNT,
    localparam int ADDR_W = NIB_CNT + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] data_i,
    input logic              sel_n,
    input logic [ADDR_W-1:0] addr_n,
    input logic [CODE_W-1:0] stage_q,
    input logic [CODE_W-1:0] code_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (code_o == '0 && stage_q == '0));

    // R2
    deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> ($stable(code_o) && $stable(stage_q)));

    // R3
    no_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && (&addr_n)) |=> ($stable(code_o) && $stable(stage_q)));

    for (genvar k = 0; k < NIB_CNT; k++) begin : g_nib_chk
        // R4
        nibble_load_chk: assert property (@(posedge clk) disable iff (rst)
            (!sel_n && !addr_n[k]) |=>
                (stage_q[k*NIB_W +: NIB_W] == $past(data_i[k*NIB_W +: NIB_W])));
    end

    // R5
    stage_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && addr_n[NIB_CNT]) |=> $stable(code_o));

    // R6
    commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && addr_n == {1'b0, {NIB_CNT{1'b1}}}) |=> (code_o == $past(stage_q)));

    // R8
    flow_through_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && addr_n == '0) |=> (code_o == $past(data_i)));

endmodule

bind dbuf_dac_latch dbuf_dac_latch_chk #(
    .NIB_W   (NIB_W),
    .NIB_CNT (NIB_CNT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .data_i  (data_i),
    .sel_n   (sel_n),
    .addr_n  (addr_n),
    .stage_q (stage_q),
    .code_o  (code_o)
);

// File: tb/dbuf_dac_latch_bench.sv
`timescale 1ns/1ps
module dbuf_dac_latch_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] data_i;
    logic        sel_n;
    logic [3:0]  addr_n;
    logic [11:0] code_o;

    int total = 0;
    int bad   = 0;

    logic [3:0]  m_nib [3];
    logic [11:0] m_code;

    always #2.5 clk = ~clk;

    dbuf_dac_latch u_dbuf_dac_latch (
        .clk    (clk),
        .rst    (rst),
        .data_i (data_i),
        .sel_n  (sel_n),
        .addr_n (addr_n),
        .code_o (code_o)
    );

    task automatic check(input logic [11:0] act, input logic [11:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: code_o=%03h expected %03h", req, act, exp);
        end
    endtask

    function automatic string tag_for(input logic s, input logic [3:0] a);
        if (s)             return "R2";
        if (a == 4'b1111)  return "R3";
        if (a == 4'b0000)  return "R8";
        if (a == 4'b0111)  return "R6";
        if (!a[3])         return "R7";
        return "R5";
    endfunction

    // one bus cycle: drive on falling edge, model update, compare after rising edge
    task automatic step(input logic s, input logic [3:0] a, input logic [11:0] d, input string req);
        @(negedge clk);
        sel_n  = s;
        addr_n = a;
        data_i = d;
        if (!s) begin
            for (int k = 0; k < 3; k++) begin
                if (!a[k]) m_nib[k] = d[k*4 +: 4];
            end
            if (!a[3]) m_code = {m_nib[2], m_nib[1], m_nib[0]};
        end
        @(posedge clk);
        #1;
        check(code_o, m_code, req);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, code_o=%03h expected completion", code_o);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst    = 1'b1;
        sel_n  = 1'b1;
        addr_n = 4'hF;
        data_i = 12'h000;
        for (int k = 0; k < 3; k++) m_nib[k] = 4'h0;
        m_code = 12'h000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(code_o, 12'h000, "R1");

        // R1: a transfer straight after reset shows the cleared first rank
        step(1'b0, 4'b0111, 12'hFFF, "R1");
        check(code_o, 12'h000, "R1");

        // R4, R5: fill nibbles one at a time, the output must not move
        step(1'b0, 4'b1110, 12'hABC, "R5");
        step(1'b0, 4'b1101, 12'h5D0, "R5");
        step(1'b0, 4'b1011, 12'h9EE, "R5");
        check(code_o, 12'h000, "R5");
        step(1'b0, 4'b0111, 12'h000, "R4");
        check(code_o, 12'h9DC, "R4");

        // R9: enables released, data moves, nothing captured
        step(1'b1, 4'b0000, 12'hFFF, "R9");
        step(1'b0, 4'b1111, 12'h321, "R9");
        step(1'b0, 4'b0111, 12'h777, "R9");
        check(code_o, 12'h9DC, "R9");

        // R7: low nibble and transfer on the same edge
        step(1'b0, 4'b0110, 12'h123, "R7");
        check(code_o, 12'h9D3, "R7");

        // R8: full transparency follows the bus every edge
        step(1'b0, 4'b0000, 12'h7A5, "R8");
        check(code_o, 12'h7A5, "R8");
        step(1'b0, 4'b0000, 12'h0F0, "R8");
        check(code_o, 12'h0F0, "R8");

        // R2, R3, R5, R6, R7, R8: sweep every select/address pattern
        for (int pass = 0; pass < 4; pass++) begin
            for (int s = 0; s < 2; s++) begin
                for (int a = 0; a < 16; a++) begin
                    logic [11:0] d;
                    d = 12'((pass * 16 + s * 8 + a) * 1103 + 12'h5A3);
                    step(s[0], a[3:0], d, tag_for(s[0], a[3:0]));
                end
            end
        end

        // reset mid-run returns to zero
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        for (int k = 0; k < 3; k++) m_nib[k] = 4'h0;
        m_code = 12'h000;
        check(code_o, 12'h000, "R1");
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 4'b0111, 12'hFFF, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule